// File: doc/BRIEF.md
# Drive Controller Host Register Interface

This block is the register file that a host processor uses to drive the payload logic of a disk-drive controller. The host reaches it over a small synchronous bus with an address, a write byte, a read byte and separate write and read strobes. Behind that bus sit three configuration registers (track count, sector count, recording mode with the interrupt enable), a command register with its track operand, read-only status and error views, and one data port. Through the data port, 32-bit drive words move as four successive bytes, least significant byte first.

Every writable location returns its last written value when read. The command register and the status view have separate addresses. The position within the current four-byte word appears in status at all times, so driver software never needs a shadow counter to track it. A completed transfer raises a sticky flag that can drive an interrupt. A data-ready or data-needed condition drives a DMA request line instead.

Top module: `drv_host_regs`

## Requirements
- R1: Locations 0 (track count), 1 (sector count) and 2 (mode) reset to zero and read back the last written byte. Mode bits [1:0] drive `cfg_format` and bit 7 is the interrupt enable.
- R2: A write to location 3 drives `cmd_pulse` with write-byte bits [5:0] for exactly the next cycle, then zero. Bit 0 is spin up, 1 spin down, 2 eject, 3 seek, 4 read sector and 5 write sector. Reading location 3 returns the full last written byte.
- R3: Location 4 holds the seek track number. It reads back and drives `seek_track`.
- R4: Location 5 reads as {2'b00, byte index[1:0], write protect, at speed, data ready, transfer done}. Location 6 reads as the head track and location 7 reads as {4'b0000, error flags}.
- R5: The byte index starts at 0, advances by one on each read or write of location 8 and wraps from 3 to 0.
- R6: A command write with bit 4 or bit 5 set returns the byte index to 0.
- R7: A write to location 8 at index k fills byte k (bits 8k+7:8k) of the outgoing word. The write at index 3 updates `host_word_out` and pulses `host_word_valid` for one cycle.
- R8: A read of location 8 at index k returns byte k of `disk_word_in`. The read at index 3 pulses `disk_word_take` for one cycle.
- R9: The transfer-done flag is set by a cycle of `st_xfer_done`, holds until a write to location 5 with bit 0 set clears it, and a set in the same cycle wins over a clear.
- R10: `irq` is high exactly while the transfer-done flag and the interrupt enable are both set.
- R11: `dma_req` follows `st_data_rdy` one cycle later.
- R12: Reads return their value on `bus_rdata` one cycle after the read strobe, and `bus_rdata` holds until the next read. Locations 9 to 15 read as zero. Writes to them and to locations 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register location |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (never together with bus_wr) |
| bus_rdata | output | 8 | Registered read byte |
| cfg_tracks | output | 8 | Configured track count |
| cfg_sectors | output | 8 | Configured sector count |
| cfg_format | output | 2 | Recording format |
| cmd_pulse | output | 6 | One-cycle command bits |
| seek_track | output | 8 | Seek target track |
| st_xfer_done | input | 1 | Transfer finished event |
| st_data_rdy | input | 1 | Data ready or needed |
| st_at_speed | input | 1 | Disk at speed |
| st_wprot | input | 1 | Disk write protected |
| st_head_track | input | 8 | Current head track |
| st_err | input | 4 | Error flags |
| disk_word_in | input | 32 | Word read from the disk |
| disk_word_take | output | 1 | Word fully consumed by the host |
| host_word_out | output | 32 | Word assembled from host bytes |
| host_word_valid | output | 1 | Assembled word is new |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench targets the byte index at its edges: the wrap after the fourth access, and a reset by a read or write command in the middle of a word. A design that gets the wrap wrong misplaces bytes in `host_word_out` or loses the take pulse. One that ignores the command reset leaves software misaligned by the number of stale bytes. The bench also issues a done event in the same cycle as its clear, where a wrong priority loses the interrupt. It writes to unmapped and read-only locations, where a loose decoder would corrupt a configuration register or return garbage.

// File: rtl/drv_regs_pkg.sv
package drv_regs_pkg;
  localparam int ADDR_W     = 4;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * BYTE_W;
  localparam int IDX_W      = $clog2(WORD_BYTES);
  localparam int CMD_N      = 6;
  localparam int ERR_W      = 4;
  localparam int C_RDSEC    = 4;
  localparam int C_WRSEC    = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_TRACKS  = 4'd0,
    A_SECTORS = 4'd1,
    A_MODE    = 4'd2,
    A_CMD     = 4'd3,
    A_SEEK    = 4'd4,
    A_STAT    = 4'd5,
    A_HEAD    = 4'd6,
    A_ERR     = 4'd7,
    A_DATA    = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic [1:0]       pad;
    logic [IDX_W-1:0] idx;
    logic             wprot;
    logic             at_speed;
    logic             data_rdy;
    logic             done;
  } stat_t;

  function automatic logic [BYTE_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                  input logic [IDX_W-1:0] i);
    return w[BYTE_W*i +: BYTE_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(WORD_BYTES-1)) ? '0 : i + 1'b1;
  endfunction
endpackage

// File: rtl/drv_byte_seq.sv
module drv_byte_seq
  import drv_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              seq_rst,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WORD_W-1:0] rd_word,
  output logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [WORD_W-1:0] wr_word,
  output logic              wr_valid,
  output logic              rd_take
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BYTES-1);

  logic [WORD_BYTES-2:0][BYTE_W-1:0] lane_w;
  logic [WORD_W-1:0] asm_word;
  logic last_wr, last_rd;

  assign last_wr = data_wr && (idx == LAST);
  assign last_rd = data_rd && (idx == LAST);

  for (genvar g = 0; g < WORD_BYTES-1; g++) begin : g_lane
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 q <= '0;
      else if (data_wr && idx == IDX_W'(g))       q <= wdata;
    end
    assign lane_w[g] = q;
  end

  always_comb begin
    asm_word = '0;
    for (int k = 0; k < WORD_BYTES-1; k++) asm_word[BYTE_W*k +: BYTE_W] = lane_w[k];
    asm_word[WORD_W-1 -: BYTE_W] = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      wr_word  <= '0;
      wr_valid <= 1'b0;
      rd_take  <= 1'b0;
    end else begin
      if (seq_rst)                  idx <= '0;
      else if (data_wr || data_rd)  idx <= idx_next(idx);
      if (last_wr) wr_word <= asm_word;
      wr_valid <= last_wr;
      rd_take  <= last_rd;
    end
  end

  assign rd_byte = lane_pick(rd_word, idx);
endmodule

// File: rtl/drv_event_unit.sv
module drv_event_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_done_ev,
  input  logic done_clr,
  input  logic irq_en,
  input  logic data_rdy,
  output logic done_q,
  output logic irq,
  output logic dma_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (xfer_done_ev)  done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      dma_req <= data_rdy;
    end
  end

  assign irq = done_q && irq_en;
endmodule

// File: rtl/drv_host_regs.sv
module drv_host_regs
  import drv_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] cfg_tracks,
  output logic [BYTE_W-1:0] cfg_sectors,
  output logic [1:0]        cfg_format,
  output logic [CMD_N-1:0]  cmd_pulse,
  output logic [BYTE_W-1:0] seek_track,
  input  logic              st_xfer_done,
  input  logic              st_data_rdy,
  input  logic              st_at_speed,
  input  logic              st_wprot,
  input  logic [BYTE_W-1:0] st_head_track,
  input  logic [ERR_W-1:0]  st_err,
  input  logic [WORD_W-1:0] disk_word_in,
  output logic              disk_word_take,
  output logic [WORD_W-1:0] host_word_out,
  output logic              host_word_valid,
  output logic              irq,
  output logic              dma_req
);
  logic [BYTE_W-1:0] mode_q, cmd_last_q;
  logic [BYTE_W-1:0] rd_mux, data_byte;
  logic [IDX_W-1:0]  byte_idx;
  logic              cmd_wr, data_wr, data_rd, seq_rst, done_clr, done_q;
  stat_t             stat_view;

  assign cmd_wr   = bus_wr && (bus_addr == A_CMD);
  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign data_rd  = bus_rd && (bus_addr == A_DATA);
  assign seq_rst  = cmd_wr && (bus_wdata[C_RDSEC] || bus_wdata[C_WRSEC]);
  assign done_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_tracks  <= '0;
      cfg_sectors <= '0;
      mode_q      <= '0;
      cmd_last_q  <= '0;
      seek_track  <= '0;
      cmd_pulse   <= '0;
    end else begin
      if (bus_wr && bus_addr == A_TRACKS)  cfg_tracks  <= bus_wdata;
      if (bus_wr && bus_addr == A_SECTORS) cfg_sectors <= bus_wdata;
      if (bus_wr && bus_addr == A_MODE)    mode_q      <= bus_wdata;
      if (bus_wr && bus_addr == A_SEEK)    seek_track  <= bus_wdata;
      if (cmd_wr)                          cmd_last_q  <= bus_wdata;
      cmd_pulse <= cmd_wr ? bus_wdata[CMD_N-1:0] : '0;
    end
  end

  assign cfg_format = mode_q[1:0];

  drv_byte_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .seq_rst  (seq_rst),
    .wdata    (bus_wdata),
    .rd_word  (disk_word_in),
    .idx      (byte_idx),
    .rd_byte  (data_byte),
    .wr_word  (host_word_out),
    .wr_valid (host_word_valid),
    .rd_take  (disk_word_take)
  );

  drv_event_unit evt_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_done_ev (st_xfer_done),
    .done_clr     (done_clr),
    .irq_en       (mode_q[7]),
    .data_rdy     (st_data_rdy),
    .done_q       (done_q),
    .irq          (irq),
    .dma_req      (dma_req)
  );

  always_comb begin
    stat_view          = '0;
    stat_view.idx      = byte_idx;
    stat_view.wprot    = st_wprot;
    stat_view.at_speed = st_at_speed;
    stat_view.data_rdy = st_data_rdy;
    stat_view.done     = done_q;
  end

  always_comb begin
    case (bus_addr)
      A_TRACKS:  rd_mux = cfg_tracks;
      A_SECTORS: rd_mux = cfg_sectors;
      A_MODE:    rd_mux = mode_q;
      A_CMD:     rd_mux = cmd_last_q;
      A_SEEK:    rd_mux = seek_track;
      A_STAT:    rd_mux = stat_view;
      A_HEAD:    rd_mux = st_head_track;
      A_ERR:     rd_mux = BYTE_W'(st_err);
      A_DATA:    rd_mux = data_byte;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/drv_host_regs_chk.sv
module drv_host_regs_chk
  import drv_regs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [CMD_N-1:0]  cmd_pulse,
  input logic              st_xfer_done,
  input logic              st_data_rdy,
  input logic              irq,
  input logic              dma_req,
  input logic              host_word_valid,
  input logic              disk_word_take,
  input logic              done_q,
  input logic              done_clr,
  input logic [IDX_W-1:0]  byte_idx,
  input logic              data_wr,
  input logic              data_rd,
  input logic              seq_rst
);
  // R2
  cmd_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> $past(bus_wr && bus_addr == A_CMD));

  // R5
  idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_idx) |-> $past(data_wr || data_rd || seq_rst));

  // R7
  word_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_word_valid |-> ($past(data_wr) && $past(byte_idx) == IDX_W'(WORD_BYTES-1)));

  // R8
  word_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disk_word_take |-> ($past(data_rd) && $past(byte_idx) == IDX_W'(WORD_BYTES-1)));

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_xfer_done) && $past(rst_n)) |-> done_q);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_q) && !$past(done_clr)) |-> done_q);

  // R10
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q);

  // R11
  dma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(st_data_rdy));

  // R11
  dma_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_data_rdy) && $past(rst_n)) |-> dma_req);

  // R12
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && $past(bus_addr) > A_DATA) |-> (bus_rdata == '0));
endmodule

bind drv_host_regs drv_host_regs_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_addr        (bus_addr),
  .bus_wr          (bus_wr),
  .bus_rd          (bus_rd),
  .bus_rdata       (bus_rdata),
  .cmd_pulse       (cmd_pulse),
  .st_xfer_done    (st_xfer_done),
  .st_data_rdy     (st_data_rdy),
  .irq             (irq),
  .dma_req         (dma_req),
  .host_word_valid (host_word_valid),
  .disk_word_take  (disk_word_take),
  .done_q          (done_q),
  .done_clr        (done_clr),
  .byte_idx        (byte_idx),
  .data_wr         (data_wr),
  .data_rd         (data_rd),
  .seq_rst         (seq_rst)
);

// File: tb/drv_host_regs_tb_top.sv
`timescale 1ns/1ps
module drv_host_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata, cfg_tracks, cfg_sectors, seek_track, st_head_track = 8'h00;
  logic [1:0]  cfg_format;
  logic [5:0]  cmd_pulse;
  logic        st_xfer_done = 0, st_data_rdy = 0, st_at_speed = 0, st_wprot = 0;
  logic [3:0]  st_err = '0;
  logic [31:0] disk_word_in = '0, host_word_out;
  logic        disk_word_take, host_word_valid, irq, dma_req;

  int errors = 0, checks = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  drv_host_regs dut_i (.*);

  // behavioural reference model
  logic [7:0]  m_reg [0:4];
  logic [7:0]  m_rdata, m_lane [0:3];
  logic [5:0]  m_pulse;
  logic [31:0] m_wword;
  logic        m_wvalid, m_take, m_done, m_dma;
  int          m_idx;

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: return m_reg[a];
      4'd5: return {2'b00, 2'(m_idx), st_wprot, st_at_speed, st_data_rdy, m_done};
      4'd6: return st_head_track;
      4'd7: return {4'b0000, st_err};
      4'd8: return disk_word_in[8*m_idx +: 8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_reg[i] = '0;
      for (int i = 0; i < 4; i++) m_lane[i] = '0;
      m_rdata = 0; m_pulse = 0; m_wword = 0; m_wvalid = 0; m_take = 0;
      m_done = 0; m_dma = 0; m_idx = 0;
    end else begin
      if (bus_rd) m_rdata = m_read(bus_addr);
      m_pulse = 0; m_wvalid = 0; m_take = 0;
      if (bus_wr && bus_addr <= 4) m_reg[bus_addr] = bus_wdata;
      if (bus_wr && bus_addr == 3) begin
        m_pulse = bus_wdata[5:0];
      end
      if (bus_addr == 8 && (bus_wr || bus_rd)) begin
        if (bus_wr) begin
          m_lane[m_idx] = bus_wdata;
          if (m_idx == 3) begin
            m_wvalid = 1;
            m_wword = {m_lane[3], m_lane[2], m_lane[1], m_lane[0]};
          end
        end else if (m_idx == 3) m_take = 1;
        m_idx = (m_idx + 1) % 4;
      end
      if (bus_wr && bus_addr == 3 && (bus_wdata[4] || bus_wdata[5])) m_idx = 0;
      if (st_xfer_done) m_done = 1;
      else if (bus_wr && bus_addr == 5 && bus_wdata[0]) m_done = 0;
      m_dma = st_data_rdy;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done_run) begin
    chk(cfg_tracks == m_reg[0] && cfg_sectors == m_reg[1], "R1 cfg", {cfg_tracks, cfg_sectors}, {m_reg[0], m_reg[1]});
    chk(cfg_format == m_reg[2][1:0], "R1 format", cfg_format, m_reg[2][1:0]);
    chk(cmd_pulse == m_pulse, "R2 pulse", cmd_pulse, m_pulse);
    chk(seek_track == m_reg[4], "R3 seek", seek_track, m_reg[4]);
    chk(bus_rdata == m_rdata, "R12 rdata", bus_rdata, m_rdata);
    chk(host_word_valid == m_wvalid && host_word_out == m_wword, "R7 word", host_word_out, m_wword);
    chk(disk_word_take == m_take, "R8 take", disk_word_take, m_take);
    chk(irq == (m_done && m_reg[2][7]), "R10 irq", irq, m_done && m_reg[2][7]);
    chk(dma_req == m_dma, "R11 dma", dma_req, m_dma);
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic finish_run();
    done_run = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata == 0 && cmd_pulse == 0 && !irq && !dma_req, "R1 reset outputs", bus_rdata, 0);
    expect_rd(4'd0, 8'h00, "R1 reset tracks");

    // R1 configuration readback
    wr(4'd0, 8'd80); wr(4'd1, 8'd18); wr(4'd2, 8'h03);
    expect_rd(4'd0, 8'd80, "R1 tracks");
    expect_rd(4'd1, 8'd18, "R1 sectors");
    expect_rd(4'd2, 8'h03, "R1 mode");
    chk(cfg_format == 2'b11, "R1 format pin", cfg_format, 3);

    // R3 seek operand, R2 seek+read command
    wr(4'd4, 8'd42);
    expect_rd(4'd4, 8'd42, "R3 seek readback");
    wr(4'd3, 8'h18);
    chk(cmd_pulse == 6'h18, "R2 pulse issued", cmd_pulse, 6'h18);
    @(negedge clk);
    chk(cmd_pulse == 0, "R2 pulse self-clear", cmd_pulse, 0);
    expect_rd(4'd3, 8'h18, "R2 command readback");

    // R4 status fields
    st_at_speed = 1; st_wprot = 1; st_head_track = 8'd42; st_err = 4'h9;
    expect_rd(4'd5, 8'b0000_1100, "R4 status");
    expect_rd(4'd6, 8'd42, "R4 head track");
    expect_rd(4'd7, 8'h09, "R4 errors");

    // R5 / R7 data write sequencing
    wr(4'd8, 8'h11);
    expect_rd(4'd5, 8'b0001_1100, "R5 index after one byte");
    wr(4'd8, 8'h22); wr(4'd8, 8'h33); wr(4'd8, 8'h44);
    chk(host_word_valid && host_word_out == 32'h44332211, "R7 assembled word", host_word_out, 32'h44332211);
    expect_rd(4'd5, 8'b0000_1100, "R5 wrap to zero");

    // R8 data read sequencing
    disk_word_in = 32'hA1B2C3D4;
    expect_rd(4'd8, 8'hD4, "R8 byte0");
    expect_rd(4'd8, 8'hC3, "R8 byte1");
    expect_rd(4'd8, 8'hB2, "R8 byte2");
    rd(4'd8, v);
    chk(v == 8'hA1 && disk_word_take, "R8 byte3 and take", v, 8'hA1);

    // R6 mid-word command reset
    expect_rd(4'd8, 8'hD4, "R8 next word byte0");
    expect_rd(4'd8, 8'hC3, "R8 next word byte1");
    wr(4'd3, 8'h10);
    expect_rd(4'd5, 8'b0000_1100, "R6 index reset by read command");
    wr(4'd8, 8'hAA);
    wr(4'd3, 8'h01);
    expect_rd(4'd5, 8'b0001_1100, "R6 spin-up keeps index");
    wr(4'd3, 8'h20);
    expect_rd(4'd8, 8'hD4, "R6 index reset by write command");

    // R9 / R10 transfer done, interrupt
    wr(4'd2, 8'h83);
    @(negedge clk); st_xfer_done = 1;
    @(negedge clk); st_xfer_done = 0;
    chk(irq, "R10 irq raised", irq, 1);
    repeat (3) @(negedge clk);
    chk(irq, "R9 flag sticky", irq, 1);
    wr(4'd5, 8'h01);
    chk(!irq, "R9 write-one clear", irq, 0);
    @(negedge clk); st_xfer_done = 1; bus_addr = 4'd5; bus_wdata = 8'h01; bus_wr = 1;
    @(negedge clk); st_xfer_done = 0; bus_wr = 0;
    chk(irq, "R9 set wins over clear", irq, 1);
    wr(4'd2, 8'h03);
    chk(!irq, "R10 irq masked", irq, 0);
    expect_rd(4'd5, 8'b0001_1101, "R9 flag visible");
    wr(4'd5, 8'h01);

    // R11 DMA request
    @(negedge clk); st_data_rdy = 1;
    @(negedge clk);
    chk(dma_req, "R11 dma raised", dma_req, 1);
    st_data_rdy = 0;
    @(negedge clk);
    chk(!dma_req, "R11 dma dropped", dma_req, 0);

    // R12 unmapped and read-only locations
    wr(4'd12, 8'hFF); wr(4'd6, 8'h55); wr(4'd7, 8'h55);
    expect_rd(4'd12, 8'h00, "R12 unmapped reads zero");
    expect_rd(4'd15, 8'h00, "R12 top location zero");
    expect_rd(4'd6, 8'd42, "R12 head track untouched");
    expect_rd(4'd0, 8'd80, "R12 tracks untouched");
    expect_rd(4'd2, 8'h03, "R12 mode untouched");
    repeat (2) @(negedge clk);
    chk(bus_rdata == 8'h03, "R12 rdata holds", bus_rdata, 3);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule